// File: doc/BRIEF.md
# Interpolating Table Activation Unit

This block applies a programmable non-linear curve, such as a sigmoid, tanh or ELU shape, to a stream of signed 16-bit samples. Each beat carries four lanes, and all four lanes use the same configuration. For each lane the sample is mapped onto a fixed-point table position. The position has an integer entry number and a wide binary fraction. The unit reads the entry at that number and the entry one above it, and blends the two linearly by the fraction. An affine stage then multiplies the result by a scale, shifts it right and adds an offset, saturating to 16 bits.

Two independent tables are held on chip. Each table has its own input origin and its own index shift. A sample uses the primary table whenever its position falls inside that table. Otherwise it uses the other table, clamped to that table's ends. A single configuration bit picks which table is primary. Table words are written through a plain write port while no data is in flight. The stream side uses valid/ready handshakes and a four-stage pipeline that stalls as a whole.

Top module: `lut_act_unit`

## Requirements
- R1: Each beat carries LANES signed DW-bit samples, lane l in bits [l*DW +: DW] of `in_data` and `o_data`. Every lane is processed independently with the same configuration.
- R2: For a table with origin S and index shift K, the difference d = x - S is taken in DW+1 bits. The wide position is (d << FW) >> K. Its integer part is the entry number and its low FW bits are the fraction.
- R3: With `cfg_swap`=0, table A is primary. With `cfg_swap`=1, table B is primary. The primary table is used when d >= 0 and its integer part is at most DEPTH-1 (DEPTH = 2**AW). Otherwise the other table is used.
- R4: A sample below a table's origin reads entry 0 of that table with fraction 0. A sample whose integer part exceeds DEPTH-1 reads entry DEPTH-1 with fraction 0. When the entry number is DEPTH-1, the upper read returns entry DEPTH-1 again.
- R5: The blended value is y = y0 + (((y1 - y0) * f + 2**(FW-1)) >>> FW), computed in full width and saturated to signed DW bits. Here y0 is the entry, y1 is the next entry and f is the fraction.
- R6: The output lane is sat(((y * `cfg_scale`) >>> `cfg_pshift`) + `cfg_offset`), computed in signed arithmetic and clamped to [-2**(DW-1), 2**(DW-1)-1].
- R7: `o_sat_cnt` travels with each output beat and equals the number of its lanes that the R6 clamp altered.
- R8: With `o_ready` held high, a beat accepted at clock edge k shows `o_valid` after edge k+3. One beat per cycle is sustained.
- R9: While `o_valid` is high and `o_ready` is low, `o_data` and `o_sat_cnt` hold and `in_ready` is low. Beats are never lost, duplicated or reordered.
- R10: A write with `wr_en`=1 stores `wr_data` at `wr_addr` of table A (`wr_tab`=0) or table B (`wr_tab`=1), but only when `in_valid` is low and no beat is in the pipeline. Otherwise the write is dropped.
- R11: Synchronous active-high reset clears the pipeline, so that `o_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_data | input | LANES*DW | Packed input samples |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream can take a beat |
| o_data | output | LANES*DW | Packed output samples |
| o_sat_cnt | output | $clog2(LANES+1) | Lanes clamped by the affine stage |
| wr_en | input | 1 | Table write strobe |
| wr_tab | input | 1 | Table choice, 0 = A, 1 = B |
| wr_addr | input | AW | Table entry to write |
| wr_data | input | DW | Word to write |
| cfg_start_a | input | DW | Signed origin of table A |
| cfg_shift_a | input | SHW | Index shift of table A |
| cfg_start_b | input | DW | Signed origin of table B |
| cfg_shift_b | input | SHW | Index shift of table B |
| cfg_swap | input | 1 | Makes table B primary |
| cfg_scale | input | DW | Signed multiplier of the affine stage |
| cfg_pshift | input | PSW | Arithmetic right shift of the affine stage |
| cfg_offset | input | DW | Signed offset of the affine stage |

## Verification
The bench builds the unit with AW=4, so each table holds 16 entries, while FW stays at 35 and DW at 16. With tables this short, a full sweep of all 65536 input codes crosses every entry, both clamp ends, the last-entry read and the fallback between tables. A second strided sweep swaps the primary table and uses a negative scale, under a stalling ready pattern. Directed beats then cover exact clamp points, fixed latency, and a write dropped while beats are held in the stalled pipeline.

// File: rtl/lut_act_pkg.sv
package lut_act_pkg;
  typedef enum logic {
    TAB_A = 1'b0,
    TAB_B = 1'b1
  } tab_sel_e;
endpackage

// File: rtl/lut_act_index.sv
module lut_act_index #(
  parameter int DW  = 16,
  parameter int AW  = 9,
  parameter int FW  = 35,
  parameter int SHW = 6
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] start,
  input  logic [SHW-1:0]       sh,
  output logic                 in_rng,
  output logic [AW-1:0]        addr,
  output logic [FW-1:0]        frac
);
  localparam int DIFW = DW + 1;
  localparam int WIDE = DIFW + FW;
  localparam logic [DIFW-1:0] LAST = DIFW'((1 << AW) - 1);

  logic signed [DIFW-1:0] diff;
  logic [WIDE-1:0]        wide;
  logic [DIFW-1:0]        ipart;
  logic                   below, over;

  always_comb begin
    diff   = $signed({x[DW-1], x}) - $signed({start[DW-1], start});
    below  = diff[DIFW-1];
    wide   = {diff, {FW{1'b0}}} >> sh;
    ipart  = wide[WIDE-1:FW];
    over   = ipart > LAST;
    in_rng = !below && !over;
    if (below) begin
      addr = '0;
      frac = '0;
    end else if (over) begin
      addr = '1;
      frac = '0;
    end else begin
      addr = ipart[AW-1:0];
      frac = wide[FW-1:0];
    end
  end
endmodule

// File: rtl/lut_act_table.sv
module lut_act_table #(
  parameter int DW  = 16,
  parameter int AW  = 9,
  parameter int NRD = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      for (int r = 0; r < NRD; r++) rdata[r] <= mem[raddr[r]];
    end
  end
endmodule

// File: rtl/lut_act_blend.sv
module lut_act_blend #(
  parameter int DW = 16,
  parameter int FW = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] y0,
  input  logic signed [DW-1:0] y1,
  input  logic [FW-1:0]        frac,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + FW + 2;
  localparam logic signed [PW-1:0] MAXV = PW'(2 ** (DW - 1) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [DW:0]   d;
  logic signed [PW-1:0] prod, rnd, sum;
  logic signed [DW-1:0] y_d, lo, hi;

  always_comb begin
    d    = $signed({y1[DW-1], y1}) - $signed({y0[DW-1], y0});
    prod = PW'(d) * PW'($signed({1'b0, frac}));
    rnd  = (prod + (PW'(1) <<< (FW - 1))) >>> FW;
    sum  = rnd + PW'(y0);
    if (sum > MAXV)      y_d = MAXV[DW-1:0];
    else if (sum < MINV) y_d = MINV[DW-1:0];
    else                 y_d = sum[DW-1:0];
    lo = (y0 < y1) ? y0 : y1;
    hi = (y0 < y1) ? y1 : y0;
  end

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= y_d;
  end

  // R5: blended value never leaves the span of the two entries
  p_between_r5: assert property (@(posedge clk) disable iff (rst)
    en |=> (y >= $past(lo)) && (y <= $past(hi)));
endmodule

// File: rtl/lut_act_post.sv
module lut_act_post #(
  parameter int DW  = 16,
  parameter int PSW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] y,
  input  logic signed [DW-1:0] scale,
  input  logic [PSW-1:0]       shift,
  input  logic signed [DW-1:0] offset,
  output logic signed [DW-1:0] z,
  output logic                 sat_d
);
  localparam int MW = 2 * DW;
  localparam int PW = MW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'(2 ** (DW - 1) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [MW-1:0] prod, shd;
  logic signed [PW-1:0] sum;
  logic signed [DW-1:0] z_d;

  always_comb begin
    prod  = MW'(y) * MW'(scale);
    shd   = prod >>> shift;
    sum   = PW'(shd) + PW'(offset);
    sat_d = (sum > MAXV) || (sum < MINV);
    if (sum > MAXV)      z_d = MAXV[DW-1:0];
    else if (sum < MINV) z_d = MINV[DW-1:0];
    else                 z_d = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     z <= '0;
    else if (en) z <= z_d;
  end

  // R6: a clamped lane lands on one of the two rails
  p_sat_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (en && sat_d) |=> (z == MAXV[DW-1:0]) || (z == MINV[DW-1:0]));
endmodule

// File: rtl/lut_act_unit.sv
module lut_act_unit
  import lut_act_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int AW    = 9,
  parameter int FW    = 35,
  parameter int SHW   = 6,
  parameter int PSW   = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES*DW-1:0]         in_data,
  output logic                        o_valid,
  input  logic                        o_ready,
  output logic [LANES*DW-1:0]         o_data,
  output logic [$clog2(LANES+1)-1:0]  o_sat_cnt,
  input  logic                        wr_en,
  input  logic                        wr_tab,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic signed [DW-1:0]        cfg_start_a,
  input  logic [SHW-1:0]              cfg_shift_a,
  input  logic signed [DW-1:0]        cfg_start_b,
  input  logic [SHW-1:0]              cfg_shift_b,
  input  logic                        cfg_swap,
  input  logic signed [DW-1:0]        cfg_scale,
  input  logic [PSW-1:0]              cfg_pshift,
  input  logic signed [DW-1:0]        cfg_offset
);
  localparam int CW  = $clog2(LANES + 1);
  localparam int NRD = 2 * LANES;
  localparam logic [AW-1:0] LAST = '1;
  localparam logic signed [DW-1:0] TOPV = DW'(2 ** (DW - 1) - 1);
  localparam logic signed [DW-1:0] BOTV = -TOPV - DW'(1);

  logic adv, busy;
  logic s1_v, s2_v, s3_v, s4_v;
  logic [LANES-1:0] s1_sel, s2_sel, sat_vec, ext_vec;
  logic [AW-1:0]    s1_a0 [LANES];
  logic [AW-1:0]    s1_a1 [LANES];
  logic [FW-1:0]    s1_f  [LANES];
  logic [FW-1:0]    s2_f  [LANES];
  logic [AW-1:0]    rd_addr [NRD];
  logic [DW-1:0]    rd_a [NRD];
  logic [DW-1:0]    rd_b [NRD];
  logic signed [DW-1:0] s3_y [LANES];
  logic [LANES*DW-1:0]  out_w;
  logic [CW-1:0]        cnt_q;

  assign adv      = !s4_v || o_ready;
  assign in_ready = adv;
  assign busy     = in_valid || s1_v || s2_v || s3_v || s4_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      s4_v <= 1'b0;
      cnt_q <= '0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      s4_v <= s3_v;
      cnt_q <= CW'($countones(sat_vec));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DW-1:0] x;
    logic                 rng_a, rng_b, use_b;
    logic [AW-1:0]        ad_a, ad_b, ad_sel;
    logic [FW-1:0]        fr_a, fr_b;

    assign x = $signed(in_data[l*DW +: DW]);

    lut_act_index #(.DW(DW), .AW(AW), .FW(FW), .SHW(SHW)) u_idx_a (
      .x(x), .start(cfg_start_a), .sh(cfg_shift_a),
      .in_rng(rng_a), .addr(ad_a), .frac(fr_a));

    lut_act_index #(.DW(DW), .AW(AW), .FW(FW), .SHW(SHW)) u_idx_b (
      .x(x), .start(cfg_start_b), .sh(cfg_shift_b),
      .in_rng(rng_b), .addr(ad_b), .frac(fr_b));

    // primary table when in range, otherwise the other one (clamped)
    assign use_b  = cfg_swap ? rng_b : !rng_a;
    assign ad_sel = use_b ? ad_b : ad_a;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_sel[l] <= 1'b0;
        s1_a0[l]  <= '0;
        s1_a1[l]  <= '0;
        s1_f[l]   <= '0;
        s2_sel[l] <= 1'b0;
        s2_f[l]   <= '0;
      end else if (adv) begin
        s1_sel[l] <= use_b;
        s1_a0[l]  <= ad_sel;
        s1_a1[l]  <= (ad_sel == LAST) ? ad_sel : ad_sel + AW'(1);
        s1_f[l]   <= use_b ? fr_b : fr_a;
        s2_sel[l] <= s1_sel[l];
        s2_f[l]   <= s1_f[l];
      end
    end

    assign rd_addr[2*l]   = s1_a0[l];
    assign rd_addr[2*l+1] = s1_a1[l];

    lut_act_blend #(.DW(DW), .FW(FW)) u_blend (
      .clk(clk), .rst(rst), .en(adv),
      .y0($signed(s2_sel[l] ? rd_b[2*l]   : rd_a[2*l])),
      .y1($signed(s2_sel[l] ? rd_b[2*l+1] : rd_a[2*l+1])),
      .frac(s2_f[l]), .y(s3_y[l]));

    lut_act_post #(.DW(DW), .PSW(PSW)) u_post (
      .clk(clk), .rst(rst), .en(adv), .y(s3_y[l]),
      .scale(cfg_scale), .shift(cfg_pshift), .offset(cfg_offset),
      .z(out_w[l*DW +: DW]), .sat_d(sat_vec[l]));

    assign ext_vec[l] = (out_w[l*DW +: DW] == TOPV) || (out_w[l*DW +: DW] == BOTV);
  end

  lut_act_table #(.DW(DW), .AW(AW), .NRD(NRD)) u_tab_a (
    .clk(clk), .we(wr_en && !busy && (tab_sel_e'(wr_tab) == TAB_A)),
    .waddr(wr_addr), .wdata(wr_data), .re(adv),
    .raddr(rd_addr), .rdata(rd_a));

  lut_act_table #(.DW(DW), .AW(AW), .NRD(NRD)) u_tab_b (
    .clk(clk), .we(wr_en && !busy && (tab_sel_e'(wr_tab) == TAB_B)),
    .waddr(wr_addr), .wdata(wr_data), .re(adv),
    .raddr(rd_addr), .rdata(rd_b));

  assign o_valid   = s4_v;
  assign o_data    = out_w;
  assign o_sat_cnt = cnt_q;

  // R9: a stalled output beat holds its payload
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> o_valid && $stable(o_data) && $stable(o_sat_cnt));

  // R8: an empty stage behind a leaving beat empties the output
  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_ready && !s3_v) |=> !o_valid);

  // R7: the count never exceeds the lanes sitting on a rail
  p_sat_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_sat_cnt <= CW'($countones(ext_vec))));
endmodule

// File: tb/test_lut_act_unit.sv
module test_lut_act_unit;
  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int FW    = 35;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic o_valid, o_ready = 1'b1;
  logic [63:0] o_data;
  logic [2:0] o_sat_cnt;
  logic wr_en = 1'b0, wr_tab = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic signed [15:0] st_a = 0, st_b = 0, scale = 1, offset = 0;
  logic [5:0] sh_a = 0, sh_b = 0, psh = 0;
  logic swap = 1'b0;

  lut_act_unit #(.LANES(LANES), .DW(DW), .AW(AW), .FW(FW), .SHW(6), .PSW(6)) i_lut_act_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_sat_cnt(o_sat_cnt),
    .wr_en(wr_en), .wr_tab(wr_tab), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_start_a(st_a), .cfg_shift_a(sh_a), .cfg_start_b(st_b), .cfg_shift_b(sh_b),
    .cfg_swap(swap), .cfg_scale(scale), .cfg_pshift(psh), .cfg_offset(offset));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  int acc_cyc = 0, out_cyc = 0;
  bit lat_arm = 0, mon_en = 0, done = 0;
  int tab_m [2][DEPTH];
  logic [63:0] exp_q[$];
  logic [2:0]  expc_q[$];
  string       tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit held = 0;
  logic [63:0] held_data;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: o_ready <= 1'b1;
      1: o_ready <= 1'b0;
      default: o_ready <= lfsr[0] | lfsr[3];
    endcase
  end

  function automatic void idx_m(input int x, input int st, input int sh,
                                output bit inr, output int ad, output longint fr);
    int diff;
    longint w, ip;
    diff = x - st;
    if (diff < 0) begin
      inr = 0; ad = 0; fr = 0;
    end else begin
      w  = (longint'(diff) <<< 35) >> sh;
      ip = w >>> 35;
      if (ip > DEPTH - 1) begin
        inr = 0; ad = DEPTH - 1; fr = 0;
      end else begin
        inr = 1; ad = int'(ip); fr = w & ((64'sd1 <<< 35) - 1);
      end
    end
  endfunction

  function automatic int clamp16(input longint v, output bit s);
    s = (v > 32767) || (v < -32768);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic void lane_m(input int x, output int z, output bit s);
    bit ina, inb, selb, dummy;
    int aa, ab, a0, a1, y0, y1, y;
    longint fa, fb, f, p, r, q;
    idx_m(x, int'(st_a), int'(sh_a), ina, aa, fa);
    idx_m(x, int'(st_b), int'(sh_b), inb, ab, fb);
    selb = swap ? inb : !ina;
    a0 = selb ? ab : aa;
    f  = selb ? fb : fa;
    a1 = (a0 == DEPTH - 1) ? a0 : a0 + 1;
    y0 = tab_m[selb][a0];
    y1 = tab_m[selb][a1];
    p  = longint'(y1 - y0) * f;
    r  = (p + (64'sd1 <<< 34)) >>> 35;
    y  = clamp16(longint'(y0) + r, dummy);
    q  = (longint'(y) * longint'(scale)) >>> psh;
    z  = clamp16(q + longint'(offset), s);
  endfunction

  task automatic send(input logic [63:0] d, input string tag);
    logic [63:0] e;
    int c, z;
    bit s;
    c = 0;
    for (int l = 0; l < LANES; l++) begin
      lane_m(int'($signed(d[l*16 +: 16])), z, s);
      e[l*16 +: 16] = z[15:0];
      c += int'(s);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #8;
    while (!in_ready) begin
      @(negedge clk);
      #8;
    end
    exp_q.push_back(e);
    expc_q.push_back(c[2:0]);
    tag_q.push_back(tag);
    acc_cyc = cyc;
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic twrite(input bit t, input int a, input int v, input bit taken);
    @(negedge clk);
    wr_en = 1'b1; wr_tab = t; wr_addr = AW'(a); wr_data = v[15:0];
    @(negedge clk);
    wr_en = 1'b0;
    if (taken) tab_m[t][a] = int'($signed(v[15:0]));
  endtask

  function automatic logic [63:0] splat(input int x);
    return {4{x[15:0]}};
  endfunction

  // output monitor: samples 2 ns before each rising edge
  always begin
    @(negedge clk);
    #8;
    if (mon_en) begin
      if (held) begin
        checks++;
        if (!o_valid || o_data !== held_data) begin
          errors++;
          $display("FAIL R9 hold: valid=%0b data=%h expected data=%h", o_valid, o_data, held_data);
        end
      end
      held = o_valid && !o_ready;
      held_data = o_data;
      if (o_valid && o_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 extra beat: data=%h expected none", o_data);
        end else begin
          logic [63:0] e;
          logic [2:0] c;
          string t;
          e = exp_q.pop_front();
          c = expc_q.pop_front();
          t = tag_q.pop_front();
          if (o_data !== e || o_sat_cnt !== c) begin
            errors++;
            $display("FAIL %s: data=%h cnt=%0d expected data=%h cnt=%0d", t, o_data, o_sat_cnt, e, c);
          end
          if (lat_arm) begin
            out_cyc = cyc;
            lat_arm = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #8;
    // R11 reset state
    checks++;
    if (o_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: o_valid=%0b in_ready=%0b expected 0 1", o_valid, in_ready);
    end
    mon_en = 1;

    // load both tables while idle (R10)
    for (int i = 0; i < DEPTH; i++) begin
      twrite(1'b0, i, i * 4000 - 30000, 1'b1);
      twrite(1'b1, i, ((i * i * 251) % 40000) - 20000, 1'b1);
    end

    // configuration 1: A primary, B covers the rest
    st_a = -16384; sh_a = 11; st_b = -32768; sh_b = 12; swap = 1'b0;
    scale = 3; psh = 1; offset = 100;
    rdy_mode = 0;
    repeat (3) @(negedge clk);

    // R8 latency with an empty pipeline
    lat_arm = 1;
    send(splat(1234), "R8 single beat");
    idle_in();
    drain();
    checks++;
    if (out_cyc - acc_cyc != 4) begin
      errors++;
      $display("FAIL R8 latency: samples=%0d expected 4", out_cyc - acc_cyc);
    end

    // full sweep of all input codes, R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 16384; i++) begin
      logic [63:0] d;
      for (int l = 0; l < LANES; l++) d[l*16 +: 16] = 16'(i * 4 + l);
      send(d, "R1/R2/R3/R4/R5/R6/R7 sweep A-primary");
    end
    idle_in();
    drain();

    // configuration 2: B primary, negative scale, stalling output (R9)
    st_b = 0; sh_b = 10; swap = 1'b1;
    scale = -20000; psh = 14; offset = -50;
    rdy_mode = 2;
    for (int i = 0; i < 8192; i++) begin
      logic [63:0] d;
      for (int l = 0; l < LANES; l++) d[l*16 +: 16] = 16'(i * 8 + l * 2 + 1);
      send(d, "R3/R5/R6/R7/R9 sweep B-primary stalled");
    end
    idle_in();
    rdy_mode = 0;
    drain();

    // R4 clamp ends with unity post stage
    scale = 1; psh = 0; offset = 0;
    send({16'sd0, -16'sd16385, 16'sd32767, -16'sd32768}, "R4 clamp ends");
    idle_in();
    drain();
    checks++;
    if (tab_m[0][0] != -30000 || tab_m[0][DEPTH-1] != 30000) begin
      errors++;
      $display("FAIL R4 table model: ends=%0d %0d expected -30000 30000", tab_m[0][0], tab_m[0][DEPTH-1]);
    end

    // R10: write while beats are stalled in the pipeline is dropped
    st_a = -16384; sh_a = 11; st_b = -32768; sh_b = 12; swap = 1'b0;
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    send(splat(-6144), "R9 stalled beat 1");
    send(splat(100), "R9 stalled beat 2");
    idle_in();
    repeat (4) @(negedge clk);
    twrite(1'b0, 5, 12345, 1'b0);
    rdy_mode = 0;
    drain();
    send(splat(-6144), "R10 write while busy ignored");
    idle_in();
    drain();
    twrite(1'b0, 5, 12345, 1'b1);
    send(splat(-6144), "R10 idle write taken");
    idle_in();
    drain();
    checks++;
    if (tab_m[0][5] != 12345) begin
      errors++;
      $display("FAIL R10 model entry: %0d expected 12345", tab_m[0][5]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule